// File: doc/BRIEF.md
# Dual-Segment Base-Bound Address Translator

This block relocates program-relative addresses into physical addresses by means of two independent segments. Instruction fetches go through a program segment, and loads and stores go through a data segment. Each segment has a base and a limit. An effective address is legal when it does not exceed the limit of its segment. A legal address is translated by adding the base of that segment. An address above the limit raises a violation flag and produces no physical address.

The two lanes work in parallel. The fetch lane translates its address on every cycle. The data lane translates only when its request strobe is high. Each lane gives a registered result one cycle after the request. The four segment registers sit behind a small configuration port. That port accepts writes and returns readback only while the supervisor input is high. A write attempted from user mode leaves the registers untouched and raises a one-cycle privilege-error pulse.

Top module: `dual_seg_relocator`

## Requirements
- R1: An active-low asynchronous reset clears all four segment registers and all registered outputs to zero.
- R2: One clock after the fetch address is presented, fetchOk is 1 and fetchPhys equals the program base plus the fetch address, provided the address is no greater than the program limit.
- R3: An address greater than the limit of its segment gives fault=1, ok=0 and a physical address of zero on that lane in the following cycle.
- R4: The data lane translates against the data base and data limit only. In the cycle after a cycle with dataReq=0, dataValid, dataFault and dataPhys are all zero.
- R5: An effective address exactly equal to the segment limit is legal.
- R6: When supervisor=1 and cfgWrEn=1, cfgWrData is written at the clock edge into the register chosen by cfgSel: 0 = program base, 1 = program limit, 2 = data base, 3 = data limit. A request in the same cycle as the write still uses the old value.
- R7: When supervisor=0, a write leaves every register unchanged, and privErr is 1 for exactly the one cycle after the attempt. At all other times privErr is 0.
- R8: cfgRdData shows, combinationally, the register chosen by cfgSel while supervisor=1, and shows zero while supervisor=0.
- R9: Fetch and data translations presented in the same cycle both complete in the next cycle, each with its own pair of registers.
- R10: The sum of base and address wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | 1 when the processor runs in privileged mode |
| cfgWrEn | input | 1 | Write strobe for a segment register |
| cfgSel | input | 2 | Register select (see R6) |
| cfgWrData | input | AW | Value to write |
| cfgRdData | output | AW | Readback of the selected register (see R8) |
| fetchAddr | input | AW | Effective instruction-fetch address |
| dataReq | input | 1 | Data access request |
| dataAddr | input | AW | Effective data address |
| fetchOk | output | 1 | Fetch translation legal |
| fetchFault | output | 1 | Fetch bounds violation |
| fetchPhys | output | AW | Translated fetch address |
| dataValid | output | 1 | Data translation legal |
| dataFault | output | 1 | Data bounds violation |
| dataPhys | output | AW | Translated data address |
| privErr | output | 1 | One-cycle pulse after a user-mode write attempt |

## Verification
The hardest case to reach from the ports is a register write and a translation on the same edge. The result must follow the old register contents, while the next request follows the new ones. The stimulus table sets this up by writing the data base in the same cycle as a data request. It then repeats that request one vector later and expects the wrapped sum under the new base. User-mode writes are checked in two steps: the bench first watches a later translation, which must be unchanged, and then raises supervisor to read the registers back through the configuration port.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  localparam int NUM_SEG_REGS = 4;
  localparam int NUM_LANES    = 2;
  localparam int SEL_W        = $clog2(NUM_SEG_REGS);

  // register order matters: lane l uses base at 2*l and limit at 2*l+1
  typedef enum logic [SEL_W-1:0] {
    SEL_PROG_BASE  = 2'd0,
    SEL_PROG_LIMIT = 2'd1,
    SEL_DATA_BASE  = 2'd2,
    SEL_DATA_LIMIT = 2'd3
  } segSel_e;

  typedef struct packed {
    logic [NUM_SEG_REGS-1:0] wrStrobe;
    logic                    rdEnable;
    logic [SEL_W-1:0]        rdSel;
  } segCtrl_t;
endpackage

// File: rtl/reloc_ctrl.sv
module reloc_ctrl
  import reloc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             supervisor,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgSel,
  output segCtrl_t         ctrl,
  output logic             privErr
);
  logic userWrite;

  assign userWrite = cfgWrEn && !supervisor;

  always_comb begin
    ctrl          = '0;
    ctrl.rdEnable = supervisor;
    ctrl.rdSel    = cfgSel;
    for (int r = 0; r < NUM_SEG_REGS; r++) begin
      ctrl.wrStrobe[r] = cfgWrEn && supervisor && (cfgSel == SEL_W'(r));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privErr <= 1'b0;
    else       privErr <= userWrite;
  end
endmodule

// File: rtl/reloc_lane.sv
module reloc_lane #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic [AW-1:0] effAddr,
  input  logic [AW-1:0] segBase,
  input  logic [AW-1:0] segLimit,
  output logic          okQ,
  output logic          faultQ,
  output logic [AW-1:0] physQ
);
  logic          inRange;
  logic [AW-1:0] sum;

  assign inRange = (effAddr <= segLimit);
  assign sum     = segBase + effAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okQ    <= 1'b0;
      faultQ <= 1'b0;
      physQ  <= '0;
    end else begin
      okQ    <= req && inRange;
      faultQ <= req && !inRange;
      physQ  <= (req && inRange) ? sum : '0;
    end
  end
endmodule

// File: rtl/reloc_datapath.sv
module reloc_datapath
  import reloc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  segCtrl_t                       ctrl,
  input  logic [AW-1:0]                  cfgWrData,
  output logic [AW-1:0]                  cfgRdData,
  input  logic [NUM_LANES-1:0]           laneReq,
  input  logic [NUM_LANES-1:0][AW-1:0]   laneAddr,
  output logic [NUM_LANES-1:0]           laneOk,
  output logic [NUM_LANES-1:0]           laneFault,
  output logic [NUM_LANES-1:0][AW-1:0]   lanePhys
);
  logic [NUM_SEG_REGS-1:0][AW-1:0] segReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segReg <= '0;
    end else begin
      for (int r = 0; r < NUM_SEG_REGS; r++) begin
        if (ctrl.wrStrobe[r]) segReg[r] <= cfgWrData;
      end
    end
  end

  assign cfgRdData = ctrl.rdEnable ? segReg[ctrl.rdSel] : '0;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    reloc_lane #(.AW(AW)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .req      (laneReq[l]),
      .effAddr  (laneAddr[l]),
      .segBase  (segReg[2*l]),
      .segLimit (segReg[2*l+1]),
      .okQ      (laneOk[l]),
      .faultQ   (laneFault[l]),
      .physQ    (lanePhys[l])
    );
  end
endmodule

// File: rtl/dual_seg_relocator.sv
module dual_seg_relocator
  import reloc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supervisor,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSel,
  input  logic [AW-1:0]    cfgWrData,
  output logic [AW-1:0]    cfgRdData,
  input  logic [AW-1:0]    fetchAddr,
  input  logic             dataReq,
  input  logic [AW-1:0]    dataAddr,
  output logic             fetchOk,
  output logic             fetchFault,
  output logic [AW-1:0]    fetchPhys,
  output logic             dataValid,
  output logic             dataFault,
  output logic [AW-1:0]    dataPhys,
  output logic             privErr
);
  localparam int FETCH_LANE = 0;
  localparam int DATA_LANE  = 1;

  segCtrl_t                     ctrl;
  logic [NUM_LANES-1:0]         laneReq;
  logic [NUM_LANES-1:0][AW-1:0] laneAddr;
  logic [NUM_LANES-1:0]         laneOk;
  logic [NUM_LANES-1:0]         laneFault;
  logic [NUM_LANES-1:0][AW-1:0] lanePhys;

  assign laneReq[FETCH_LANE]  = 1'b1;
  assign laneReq[DATA_LANE]   = dataReq;
  assign laneAddr[FETCH_LANE] = fetchAddr;
  assign laneAddr[DATA_LANE]  = dataAddr;

  reloc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supervisor (supervisor),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .ctrl       (ctrl),
    .privErr    (privErr)
  );

  reloc_datapath #(.AW(AW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .laneReq   (laneReq),
    .laneAddr  (laneAddr),
    .laneOk    (laneOk),
    .laneFault (laneFault),
    .lanePhys  (lanePhys)
  );

  assign fetchOk    = laneOk[FETCH_LANE];
  assign fetchFault = laneFault[FETCH_LANE];
  assign fetchPhys  = lanePhys[FETCH_LANE];
  assign dataValid  = laneOk[DATA_LANE];
  assign dataFault  = laneFault[DATA_LANE];
  assign dataPhys   = lanePhys[DATA_LANE];
endmodule

// File: rtl/reloc_chk.sv
module reloc_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          supervisor,
  input logic          cfgWrEn,
  input logic [AW-1:0] cfgRdData,
  input logic          dataReq,
  input logic          fetchOk,
  input logic          fetchFault,
  input logic [AW-1:0] fetchPhys,
  input logic          dataValid,
  input logic          dataFault,
  input logic [AW-1:0] dataPhys,
  input logic          privErr
);
  p_fetch_fault_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchFault |-> (!fetchOk && fetchPhys == '0));

  p_data_fault_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataFault |-> (!dataValid && dataPhys == '0));

  p_fetch_decided_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (fetchOk ^ fetchFault));

  p_data_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dataReq |=> (!dataValid && !dataFault && dataPhys == '0));

  p_data_decided_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |=> (dataValid ^ dataFault));

  p_priv_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !supervisor) |=> privErr);

  p_priv_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && !supervisor) |=> !privErr);

  p_user_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !supervisor |-> cfgRdData == '0);
endmodule

bind dual_seg_relocator reloc_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supervisor (supervisor),
  .cfgWrEn    (cfgWrEn),
  .cfgRdData  (cfgRdData),
  .dataReq    (dataReq),
  .fetchOk    (fetchOk),
  .fetchFault (fetchFault),
  .fetchPhys  (fetchPhys),
  .dataValid  (dataValid),
  .dataFault  (dataFault),
  .dataPhys   (dataPhys),
  .privErr    (privErr)
);

// File: tb/tb_dual_seg_relocator.sv
module tb_dual_seg_relocator;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          supervisor = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgSel = 2'd0;
  logic [AW-1:0] cfgWrData = '0;
  logic [AW-1:0] cfgRdData;
  logic [AW-1:0] fetchAddr = '0;
  logic          dataReq = 1'b0;
  logic [AW-1:0] dataAddr = '0;
  logic          fetchOk, fetchFault, dataValid, dataFault, privErr;
  logic [AW-1:0] fetchPhys, dataPhys;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_seg_relocator #(.AW(AW)) dut (.*);

  typedef struct packed {
    logic        sup;
    logic        wr;
    logic [1:0]  sel;
    logic [31:0] wd;
    logic [31:0] fa;
    logic        dr;
    logic [31:0] da;
    logic        eFok;
    logic        eFflt;
    logic [31:0] eFpa;
    logic        eDv;
    logic        eDf;
    logic [31:0] eDpa;
    logic        ePriv;
  } vec_t;

  localparam int NVEC = 10;
  // expected values use the registers as they were before the edge of that vector
  localparam vec_t VECS [NVEC] = '{
    // R6 write program base; R1 zero regs: address 0 passes to phys 0
    '{1'b1,1'b1,2'd0,32'h0000_1000, 32'h0,   1'b0,32'h0,   1'b1,1'b0,32'h0,   1'b0,1'b0,32'h0, 1'b0},
    // R6 write program limit; limit still 0 so address 0x10 faults (R3)
    '{1'b1,1'b1,2'd1,32'h0000_00FF, 32'h10,  1'b0,32'h0,   1'b0,1'b1,32'h0,   1'b0,1'b0,32'h0, 1'b0},
    // R5 address equal to limit; R6 write data base
    '{1'b1,1'b1,2'd2,32'h8000_0000, 32'hFF,  1'b0,32'h0,   1'b1,1'b0,32'h10FF,1'b0,1'b0,32'h0, 1'b0},
    // R3 fetch over limit; data limit still 0 -> data fault; R6 write data limit
    '{1'b1,1'b1,2'd3,32'h0000_0400, 32'h100, 1'b1,32'h10,  1'b0,1'b1,32'h0,   1'b0,1'b1,32'h0, 1'b0},
    // R9 both lanes legal in parallel; R5 data at its limit
    '{1'b1,1'b0,2'd0,32'h0,         32'h20,  1'b1,32'h400, 1'b1,1'b0,32'h1020,1'b1,1'b0,32'h8000_0400, 1'b0},
    // R7 user write ignored, pulse; R3 data over limit
    '{1'b0,1'b1,2'd0,32'h0000_DEAD, 32'h20,  1'b1,32'h401, 1'b1,1'b0,32'h1020,1'b0,1'b1,32'h0, 1'b1},
    // R7 base unchanged, pulse gone; R4 no data request gives zeros
    '{1'b0,1'b0,2'd0,32'h0,         32'h30,  1'b0,32'h0,   1'b1,1'b0,32'h1030,1'b0,1'b0,32'h0, 1'b0},
    // R6 write data base in same cycle as a request: old base used
    '{1'b1,1'b1,2'd2,32'hFFFF_FF00, 32'h0,   1'b1,32'h200, 1'b1,1'b0,32'h1000,1'b1,1'b0,32'h8000_0200, 1'b0},
    // R10 new base wraps: FFFFFF00 + 200 = 100
    '{1'b1,1'b0,2'd0,32'h0,         32'h1,   1'b1,32'h200, 1'b1,1'b0,32'h1001,1'b1,1'b0,32'h0000_0100, 1'b0},
    // R7 user write to data limit ignored; R10 wrap again
    '{1'b0,1'b1,2'd3,32'h0,         32'h2,   1'b1,32'h400, 1'b1,1'b0,32'h1002,1'b1,1'b0,32'h0000_0300, 1'b1}
  };

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic readBack(input logic sup, input logic [1:0] sel, input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    cfgWrEn = 1'b0; supervisor = sup; cfgSel = sel;
    #1;
    chk(tag, "cfgRdData", cfgRdData, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state of outputs
    chk("R1", "fetchOk", {31'b0, fetchOk}, '0);
    chk("R1", "dataPhys", dataPhys, '0);
    chk("R1", "privErr", {31'b0, privErr}, '0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      supervisor = VECS[i].sup; cfgWrEn = VECS[i].wr; cfgSel = VECS[i].sel;
      cfgWrData = VECS[i].wd; fetchAddr = VECS[i].fa;
      dataReq = VECS[i].dr; dataAddr = VECS[i].da;
      @(posedge clk); #1;
      chk("R2", "fetchOk",    {31'b0, fetchOk},    {31'b0, VECS[i].eFok});
      chk("R3", "fetchFault", {31'b0, fetchFault}, {31'b0, VECS[i].eFflt});
      chk("R2", "fetchPhys",  fetchPhys,           VECS[i].eFpa);
      chk("R4", "dataValid",  {31'b0, dataValid},  {31'b0, VECS[i].eDv});
      chk("R4", "dataFault",  {31'b0, dataFault},  {31'b0, VECS[i].eDf});
      chk("R4", "dataPhys",   dataPhys,            VECS[i].eDpa);
      chk("R7", "privErr",    {31'b0, privErr},    {31'b0, VECS[i].ePriv});
    end
    dataReq = 1'b0;

    // R8 supervisor readback; R7 user writes left registers intact
    readBack(1'b1, 2'd0, 32'h0000_1000, "R8");
    readBack(1'b1, 2'd1, 32'h0000_00FF, "R8");
    readBack(1'b1, 2'd2, 32'hFFFF_FF00, "R8");
    readBack(1'b1, 2'd3, 32'h0000_0400, "R7");
    readBack(1'b0, 2'd0, 32'h0, "R8");

    // R7 pulse lasts one cycle only
    @(negedge clk); supervisor = 1'b0; cfgWrEn = 1'b1; cfgSel = 2'd1; cfgWrData = 32'h0;
    @(negedge clk); cfgWrEn = 1'b0;
    chk("R7", "privErr pulse", {31'b0, privErr}, 32'h1);
    @(negedge clk);
    chk("R7", "privErr after", {31'b0, privErr}, 32'h0);
    readBack(1'b1, 2'd1, 32'h0000_00FF, "R7");

    // R1 reset in mid-run clears the registers
    @(negedge clk); rstN = 1'b0;
    #1;
    chk("R1", "fetchPhys", fetchPhys, '0);
    @(negedge clk); rstN = 1'b1;
    readBack(1'b1, 2'd0, 32'h0, "R1");
    readBack(1'b1, 2'd3, 32'h0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule